// File: doc/BRIEF.md
# Eight-Channel Double-Buffered DAC Code Register Front End

This block is the clocked digital front end of an eight-channel, 13-bit voltage-output converter. A host writes a code to one channel at a time over a parallel bus: a 13-bit data word, a 3-bit channel select, a mode bit, and active-low chip-select and write strobes. The word goes into that channel's input register. A second register per channel, the DAC register, holds the code that the converter presents. One global active-low load strobe copies all eight input registers into their DAC registers in the same cycle, so every output can change together.

An active-low clear input drives every channel to a clear code, and the host can program that code. The clear code has its own register. The host writes it through the same bus with the mode bit set. All strobes are asynchronous to the system clock. Each strobe passes through a two-flop synchronizer and is then edge-detected. The bus word passes through an equal delay so that it stays aligned with its strobes. The block outputs the raw 13-bit code for each channel. Channel k occupies bits [13k+12:13k].

Top module: `octal_dac_regs`

## Requirements
- R1: After reset, every input register, every DAC register and the clear code hold mid-scale, 13'h1000 (4096).
- R2: A write occurs when cs_n and wr_n are both low and then either one rises. With bus_cfg low, it stores bus_data into the input register that bus_addr selects (0 selects channel 0, 7 selects channel 7). No DAC output changes while ld_n stays high.
- R3: The stored word is the one on the bus while both strobes were low. If the bus changes at the moment the first strobe rises, the new value is not stored, whichever strobe rises first.
- R4: A low pulse on wr_n while cs_n is high stores nothing. A low pulse on cs_n while wr_n is high also stores nothing.
- R5: While ld_n is low, all eight DAC registers take their input-register values in the same cycle. While ld_n and clr_n are both high, the DAC registers hold their values.
- R6: If ld_n is held low during a write, the addressed DAC register takes the new word on the same clock edge as its input register.
- R7: A write with bus_cfg high stores bus_data into the clear-code register and leaves every input register unchanged.
- R8: While clr_n is low, every input and DAC register is forced to the clear code. Clear overrides the load strobe, and any write that completes during clear is discarded.
- R9: A write updates its register on the third rising clock edge after the first strobe rises. A change of ld_n or clr_n takes effect on the third rising edge after it falls. No update happens on the second edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_data | input | 13 | Parallel code word |
| bus_addr | input | 3 | Channel select for a code write |
| bus_cfg | input | 1 | 1: the write targets the clear-code register |
| cs_n | input | 1 | Active-low chip select |
| wr_n | input | 1 | Active-low write strobe |
| ld_n | input | 1 | Active-low global load strobe |
| clr_n | input | 1 | Active-low clear |
| dac_code | output | 104 | Eight DAC register codes, channel k at [13k+12:13k] |

## Verification
A corrupted input register is hidden until a load. It shows at dac_code on the third edge after ld_n falls, so the bench follows every group of writes with a load and compares all eight channels. A write to the wrong channel or with the wrong word appears at once when ld_n is held low. A stale clear code appears three edges after clr_n falls. A fault in the synchronizer or in the delay alignment moves an update by one edge, or stores the word that followed the strobe. Probes placed exactly two and three edges after each strobe catch both kinds of fault.

// File: rtl/dacif_pkg.sv
package dacif_pkg;
  localparam int SYNC_STAGES = 2;
  localparam int NUM_STB     = 4;
  localparam int STB_CS      = 0;
  localparam int STB_WR      = 1;
  localparam int STB_LD      = 2;
  localparam int STB_CLR     = 3;

  typedef enum logic {
    TGT_CHAN  = 1'b0,
    TGT_CLEAR = 1'b1
  } wr_tgt_e;
endpackage

// File: rtl/dacif_rst_sync.sv
module dacif_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] stg_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stg_q <= 2'b00;
    else         stg_q <= {stg_q[0], 1'b1};
  end

  assign rst_n_o = stg_q[1];
endmodule

// File: rtl/dacif_strobe_sync.sv
module dacif_strobe_sync #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw_n,
  output logic [N-1:0] act
);
  logic [N-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '1;
      s2_q <= '1;
    end else begin
      s1_q <= raw_n;
      s2_q <= s1_q;
    end
  end

  assign act = ~s2_q;
endmodule

// File: rtl/dacif_bus_capture.sv
module dacif_bus_capture
  import dacif_pkg::*;
#(
  parameter int CODE_W = 13,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_act,
  input  logic [CODE_W-1:0] bus_data,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_cfg,
  output logic              commit,
  output logic [CODE_W-1:0] w_data,
  output logic [ADDR_W-1:0] w_addr,
  output wr_tgt_e           w_tgt
);
  localparam int WORD_W = CODE_W + ADDR_W + 1;

  logic [WORD_W-1:0] dly_q [SYNC_STAGES];
  logic [WORD_W-1:0] hold_q, hold_d;
  logic              act_q;

  // The bus is delayed by as many stages as the strobes so both stay aligned
  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_dly
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dly_q[g] <= '0;
      else if (g == 0) dly_q[g] <= {bus_cfg, bus_addr, bus_data};
      else dly_q[g] <= dly_q[g-1];
    end
  end

  always_comb begin
    hold_d = hold_q;
    if (wr_act) hold_d = dly_q[SYNC_STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      act_q  <= 1'b0;
    end else begin
      hold_q <= hold_d;
      act_q  <= wr_act;
    end
  end

  assign commit = act_q & ~wr_act;
  assign w_data = hold_q[CODE_W-1:0];
  assign w_addr = hold_q[CODE_W +: ADDR_W];
  assign w_tgt  = wr_tgt_e'(hold_q[WORD_W-1]);
endmodule

// File: rtl/dacif_channel.sv
module dacif_channel #(
  parameter int              CODE_W   = 13,
  parameter logic [CODE_W-1:0] RST_CODE = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_act,
  input  logic [CODE_W-1:0] clr_code,
  input  logic              ld_act,
  input  logic              wr_sel,
  input  logic [CODE_W-1:0] w_data,
  output logic [CODE_W-1:0] in_q,
  output logic [CODE_W-1:0] dac_q
);
  logic [CODE_W-1:0] in_d, dac_d;

  always_comb begin
    in_d  = in_q;
    dac_d = dac_q;
    if (clr_act) begin
      in_d  = clr_code;
      dac_d = clr_code;
    end else begin
      if (wr_sel) in_d  = w_data;
      if (ld_act) dac_d = in_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q  <= RST_CODE;
      dac_q <= RST_CODE;
    end else begin
      in_q  <= in_d;
      dac_q <= dac_d;
    end
  end
endmodule

// File: rtl/octal_dac_regs.sv
module octal_dac_regs
  import dacif_pkg::*;
#(
  parameter int CODE_W = 13,
  parameter int N_CH   = 8,
  localparam int ADDR_W = $clog2(N_CH)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [CODE_W-1:0]      bus_data,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic                   bus_cfg,
  input  logic                   cs_n,
  input  logic                   wr_n,
  input  logic                   ld_n,
  input  logic                   clr_n,
  output logic [N_CH*CODE_W-1:0] dac_code
);
  localparam logic [CODE_W-1:0] MID_CODE = CODE_W'(1) << (CODE_W - 1);

  logic               rst_q_n;
  logic [NUM_STB-1:0] stb_act;
  logic               wr_act, ld_act, clr_act;
  logic               commit, cfg_wr;
  logic [CODE_W-1:0]  w_data;
  logic [ADDR_W-1:0]  w_addr;
  wr_tgt_e            w_tgt;
  logic [CODE_W-1:0]  clr_code_q, clr_code_d;
  logic [N_CH*CODE_W-1:0] in_flat;

  dacif_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .rst_n_o(rst_q_n)
  );

  dacif_strobe_sync #(.N(NUM_STB)) u_stb (
    .clk  (clk),
    .rst_n(rst_q_n),
    .raw_n({clr_n, ld_n, wr_n, cs_n}),
    .act  (stb_act)
  );

  assign wr_act  = stb_act[STB_CS] & stb_act[STB_WR];
  assign ld_act  = stb_act[STB_LD];
  assign clr_act = stb_act[STB_CLR];

  dacif_bus_capture #(.CODE_W(CODE_W), .ADDR_W(ADDR_W)) u_cap (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .wr_act  (wr_act),
    .bus_data(bus_data),
    .bus_addr(bus_addr),
    .bus_cfg (bus_cfg),
    .commit  (commit),
    .w_data  (w_data),
    .w_addr  (w_addr),
    .w_tgt   (w_tgt)
  );

  assign cfg_wr = (w_tgt == TGT_CLEAR);

  always_comb begin
    clr_code_d = clr_code_q;
    if (commit && cfg_wr && !clr_act) clr_code_d = w_data;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) clr_code_q <= MID_CODE;
    else          clr_code_q <= clr_code_d;
  end

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
    logic sel;
    assign sel = commit && !cfg_wr && (w_addr == ADDR_W'(ch));

    dacif_channel #(.CODE_W(CODE_W), .RST_CODE(MID_CODE)) u_chan (
      .clk     (clk),
      .rst_n   (rst_q_n),
      .clr_act (clr_act),
      .clr_code(clr_code_q),
      .ld_act  (ld_act),
      .wr_sel  (sel),
      .w_data  (w_data),
      .in_q    (in_flat[ch*CODE_W +: CODE_W]),
      .dac_q   (dac_code[ch*CODE_W +: CODE_W])
    );
  end
endmodule

// File: rtl/octal_dac_regs_chk.sv
module octal_dac_regs_chk #(
  parameter int CODE_W = 13,
  parameter int N_CH   = 8,
  parameter int ADDR_W = 3
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   commit,
  input logic                   cfg_wr,
  input logic                   ld_act,
  input logic                   clr_act,
  input logic [ADDR_W-1:0]      w_addr,
  input logic [CODE_W-1:0]      w_data,
  input logic [CODE_W-1:0]      clr_code,
  input logic [N_CH*CODE_W-1:0] in_flat,
  input logic [N_CH*CODE_W-1:0] dac_flat
);
  // R2
  write_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit && !cfg_wr && !clr_act |=>
      in_flat[$past(w_addr)*CODE_W +: CODE_W] == $past(w_data));

  // R4
  input_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit && !clr_act |=> $stable(in_flat));

  // R5
  dac_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_act && !clr_act |=> $stable(dac_flat));

  // R5
  load_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_act && !clr_act && !commit |=> dac_flat == $past(in_flat));

  // R6
  transparent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit && !cfg_wr && ld_act && !clr_act |=>
      dac_flat[$past(w_addr)*CODE_W +: CODE_W] == $past(w_data));

  // R7
  clr_code_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit && cfg_wr && !clr_act |=> clr_code == $past(w_data));

  // R8
  clear_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_act |=> dac_flat == {N_CH{$past(clr_code)}} && in_flat == {N_CH{$past(clr_code)}});
endmodule

bind octal_dac_regs octal_dac_regs_chk #(
  .CODE_W(CODE_W), .N_CH(N_CH), .ADDR_W(ADDR_W)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_q_n),
  .commit  (commit),
  .cfg_wr  (cfg_wr),
  .ld_act  (ld_act),
  .clr_act (clr_act),
  .w_addr  (w_addr),
  .w_data  (w_data),
  .clr_code(clr_code_q),
  .in_flat (in_flat),
  .dac_flat(dac_code)
);

// File: tb/octal_dac_regs_test.sv
module octal_dac_regs_test;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 13;
  localparam int NC = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [CW-1:0] bus_data;
  logic [2:0]    bus_addr;
  logic          bus_cfg;
  logic          cs_n, wr_n, ld_n, clr_n;
  logic [NC*CW-1:0] dac_code;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [CW-1:0] exp_in  [NC];
  logic [CW-1:0] exp_dac [NC];
  logic [CW-1:0] exp_clr;

  octal_dac_regs uut (
    .clk(clk), .rst_n(rst_n), .bus_data(bus_data), .bus_addr(bus_addr),
    .bus_cfg(bus_cfg), .cs_n(cs_n), .wr_n(wr_n), .ld_n(ld_n), .clr_n(clr_n),
    .dac_code(dac_code)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check_dacs(input string req);
    bit bad = 1'b0;
    n_tests++;
    for (int i = 0; i < NC; i++) begin
      if (dac_code[i*CW +: CW] !== exp_dac[i]) begin
        $display("FAIL %s ch%0d actual=%h expected=%h", req, i,
                 dac_code[i*CW +: CW], exp_dac[i]);
        bad = 1'b1;
      end
    end
    if (bad) n_fail++;
  endtask

  task automatic check_one(input string req, input int ch, input logic [CW-1:0] e);
    n_tests++;
    if (dac_code[ch*CW +: CW] !== e) begin
      n_fail++;
      $display("FAIL %s ch%0d actual=%h expected=%h", req, ch, dac_code[ch*CW +: CW], e);
    end
  endtask

  // Write cycle; the bus word is inverted right as the first strobe rises (R3)
  task automatic bus_write(input logic [2:0] a, input logic [CW-1:0] d,
                           input bit cfg, input bit cs_first);
    @(negedge clk);
    bus_addr = a; bus_data = d; bus_cfg = cfg;
    cs_n = 1'b0; wr_n = 1'b0;
    repeat (3) @(negedge clk);
    if (cs_first) cs_n = 1'b1; else wr_n = 1'b1;
    bus_data = ~d; bus_addr = ~a;
    repeat (2) @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b1;
    repeat (4) @(negedge clk);
    if (cfg) exp_clr = d; else exp_in[a] = d;
  endtask

  task automatic load_pulse();
    @(negedge clk);
    ld_n = 1'b0;
    repeat (3) @(negedge clk);
    ld_n = 1'b1;
    repeat (4) @(negedge clk);
    for (int i = 0; i < NC; i++) exp_dac[i] = exp_in[i];
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cs_n = 1'b1; wr_n = 1'b1; ld_n = 1'b1; clr_n = 1'b1;
    bus_data = '0; bus_addr = '0; bus_cfg = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    for (int i = 0; i < NC; i++) begin exp_in[i] = 13'h1000; exp_dac[i] = 13'h1000; end
    exp_clr = 13'h1000;
  endtask

  task automatic t_reset();
    do_reset();
    check_dacs("R1 dac after reset");
    load_pulse();
    check_dacs("R1 input regs after reset");
    @(negedge clk); clr_n = 1'b0;
    repeat (4) @(negedge clk); clr_n = 1'b1;
    repeat (4) @(negedge clk);
    check_dacs("R1 clear code after reset");
  endtask

  task automatic t_write_then_load();
    bus_write(3'd3, 13'h0123, 1'b0, 1'b0);
    check_dacs("R2 no dac change before load");
    for (int i = 0; i < NC; i++)
      if (i != 3) bus_write(3'(i), CW'(13'h0200 + i * 13'h0111), 1'b0, i[0]);
    check_dacs("R2 still unloaded");
    // R9: load latency probe
    @(negedge clk); ld_n = 1'b0;
    repeat (2) @(negedge clk);
    check_one("R9 load not before third edge", 3, 13'h1000);
    @(negedge clk);
    check_one("R9 load on third edge", 3, 13'h0123);
    ld_n = 1'b1;
    repeat (4) @(negedge clk);
    for (int i = 0; i < NC; i++) exp_dac[i] = exp_in[i];
    check_dacs("R5 all channels loaded");
  endtask

  task automatic t_cs_first();
    bus_write(3'd0, 13'h1ABC, 1'b0, 1'b1);
    bus_write(3'd7, 13'h0001, 1'b0, 1'b0);
    load_pulse();
    check_dacs("R3 word from strobe window");
  endtask

  task automatic t_half_strobe();
    @(negedge clk); bus_addr = 3'd5; bus_data = 13'h0F0F; bus_cfg = 1'b0;
    wr_n = 1'b0; repeat (4) @(negedge clk); wr_n = 1'b1;
    repeat (2) @(negedge clk);
    cs_n = 1'b0; repeat (4) @(negedge clk); cs_n = 1'b1;
    repeat (4) @(negedge clk);
    load_pulse();
    check_dacs("R4 single strobe stores nothing");
  endtask

  task automatic t_transparent();
    @(negedge clk); ld_n = 1'b0;
    repeat (4) @(negedge clk);
    @(negedge clk);
    bus_addr = 3'd2; bus_data = 13'h0777; bus_cfg = 1'b0;
    cs_n = 1'b0; wr_n = 1'b0;
    repeat (3) @(negedge clk);
    wr_n = 1'b1;
    repeat (2) @(negedge clk);
    check_one("R9 write not before third edge", 2, exp_in[2]);
    @(negedge clk);
    check_one("R6 transparent write", 2, 13'h0777);
    cs_n = 1'b1;
    repeat (3) @(negedge clk);
    ld_n = 1'b1;
    repeat (3) @(negedge clk);
    exp_in[2] = 13'h0777; exp_dac[2] = 13'h0777;
    check_dacs("R6 other channels intact");
  endtask

  task automatic t_clear();
    bus_write(3'd4, 13'h0ABC, 1'b1, 1'b0);
    check_dacs("R7 cfg write leaves dacs");
    load_pulse();
    check_dacs("R7 cfg write leaves input regs");
    // R8 with R9 latency, ld also low
    @(negedge clk); clr_n = 1'b0; ld_n = 1'b0;
    repeat (2) @(negedge clk);
    check_dacs("R9 clear not before third edge");
    @(negedge clk);
    for (int i = 0; i < NC; i++) begin exp_dac[i] = exp_clr; exp_in[i] = exp_clr; end
    check_dacs("R8 clear beats load");
    ld_n = 1'b1;
    bus_write(3'd6, 13'h1555, 1'b0, 1'b0);
    exp_in[6] = exp_clr;
    bus_write(3'd1, 13'h0042, 1'b1, 1'b1);
    exp_clr = 13'h0ABC;
    @(negedge clk); clr_n = 1'b1;
    repeat (4) @(negedge clk);
    check_dacs("R8 dacs hold clear code");
    load_pulse();
    check_dacs("R8 write during clear dropped");
    @(negedge clk); clr_n = 1'b0;
    repeat (4) @(negedge clk); clr_n = 1'b1;
    repeat (4) @(negedge clk);
    check_dacs("R8 clear code unchanged by write in clear");
  endtask

  initial begin
    t_reset();
    t_write_then_load();
    t_cs_first();
    t_half_strobe();
    t_transparent();
    t_clear();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule